// File: doc/BRIEF.md
# LFSR Sequence Self-Test Checker

This block judges a captured buffer of words taken from a random number source while that source runs in a deterministic health-check setting. In that setting the source emits successive states of a linear feedback shift register. A correct source therefore leaves a buffer that holds a run of those states, but their alignment within the buffer is unknown. The buffer is loaded into a small internal register array through a write port. A start pulse then begins the search.

The checker keeps an expected value that begins at a fixed seed. In each iteration it walks the buffer one slot per clock and skips slot 0, whose word may be stale. Every slot equal to the expected value adds one to a running match total. After the last slot the total is compared with a goal. If the goal is met, the check ends with pass. Otherwise the expected value advances by one polynomial step and the next iteration begins. If the iteration limit is reached first, the check ends with fail. Completion is shown by a one-cycle done pulse, together with the verdict, the final match total and the number of iterations run.

Top module: `lfsr_selftest_chk`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and pass_o are 0, and match_cnt_o and iter_cnt_o are 0.
- R2: A word written through the write port lands in the slot given by the address. Slot 0 is never compared, so its content cannot change any result.
- R3: Each iteration adds to the running total the number of slots 1..DEPTH-1 that equal that iteration's expected value. A value that appears several times is counted each time.
- R4: At the end of the first iteration whose total is at least GOAL, the check ends with pass_o=1. match_cnt_o then shows that total, and iter_cnt_o shows the number of iterations run, counting the last one.
- R5: If LOOP_MAX iterations complete without the total reaching GOAL, the check ends with pass_o=0, iter_cnt_o=LOOP_MAX, and match_cnt_o holding the total, which is below GOAL.
- R6: The expected value of the first iteration is SEED. Between iterations it becomes (v<<1) XOR POLY when bit W-1 of the old value v is 1, and (v<<1) otherwise.
- R7: One slot is scanned per clock. done_o rises n*(DEPTH-1) clocks after the clock edge that samples start_i, where n is the number of iterations run. done_o is high for exactly one cycle. busy_o is low from that cycle on, and the verdict and counts hold until the next start.
- R8: A start_i pulse while busy_o is high is ignored: the verdict, the counts and the completion time are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Buffer slot to write |
| wr_data_i | input | W | Word to store |
| start_i | input | 1 | Begin a check (ignored while busy) |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict of the last check |
| match_cnt_o | output | $clog2(GOAL+DEPTH) | Final match total |
| iter_cnt_o | output | $clog2(LOOP_MAX+1) | Iterations run |

## Verification
On every cycle the assertions check these invariants:
- the scan slot never points at slot 0 while busy;
- the expected value holds still within an iteration;
- the total never decreases during a run;
- done is a single-cycle pulse;
- a pass verdict always carries a total at or above the goal;
- a fail verdict always carries the full iteration count.

Only the bench scenarios can show that the counts are the right ones for a given buffer. The same holds for the polynomial step across the top-bit carry, the exact completion cycle, and a start pulse mid-run leaving the result untouched. Those are checked against an arithmetic model of the search over a broad sweep of buffer contents.

// File: rtl/lfsr_chk_pkg.sv
package lfsr_chk_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } chk_state_e;
endpackage

// File: rtl/chk_buf_mem.sv
module chk_buf_mem #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && (int'(wr_addr_i) == g)) mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(rd_addr_i) == i) rd_data_o = mem_q[i];
  end
endmodule

// File: rtl/chk_lfsr_step.sv
module chk_lfsr_step #(
  parameter int           W    = 64,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  // Galois form: shift, fold polynomial back when the top bit leaves
  always_comb begin
    nxt_o = {cur_i[W-2:0], 1'b0};
    if (cur_i[W-1]) nxt_o = nxt_o ^ POLY;
  end
endmodule

// File: rtl/chk_scan_ctrl.sv
module chk_scan_ctrl
  import lfsr_chk_pkg::*;
#(
  parameter int           W        = 64,
  parameter int           DEPTH    = 16,
  parameter logic [W-1:0] SEED     = '0,
  parameter int           GOAL     = 14,
  parameter int           LOOP_MAX = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int MW = $clog2(GOAL + DEPTH),
  localparam int IW = $clog2(LOOP_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  rd_data_i,
  input  logic [W-1:0]  exp_step_i,
  output logic [AW-1:0] slot_o,
  output logic [W-1:0]  exp_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [MW-1:0] match_cnt_o,
  output logic [IW-1:0] iter_cnt_o
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [MW-1:0] GOAL_C    = MW'(GOAL);
  localparam logic [IW-1:0] ITER_LAST = IW'(LOOP_MAX - 1);
  localparam logic [IW-1:0] ITER_MAX  = IW'(LOOP_MAX);

  chk_state_e    state_q;
  logic [AW-1:0] slot_q;
  logic [W-1:0]  exp_q;
  logic [MW-1:0] total_q;
  logic [IW-1:0] iter_q;
  logic          done_q, pass_q;

  logic          hit;
  logic [MW-1:0] total_nx;
  logic          last_slot, goal_met;

  assign hit       = (rd_data_i == exp_q);
  assign total_nx  = total_q + MW'(hit);
  assign last_slot = (slot_q == LAST_SLOT);
  assign goal_met  = (total_nx >= GOAL_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= AW'(1);
      exp_q   <= SEED;
      total_q <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SCAN;
            slot_q  <= AW'(1);
            exp_q   <= SEED;
            total_q <= '0;
            iter_q  <= '0;
            pass_q  <= 1'b0;
          end
        end
        ST_SCAN: begin
          total_q <= total_nx;
          if (!last_slot) begin
            slot_q <= slot_q + AW'(1);
          end else if (goal_met) begin
            state_q <= ST_IDLE;
            iter_q  <= iter_q + IW'(1);
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
          end else if (iter_q == ITER_LAST) begin
            state_q <= ST_IDLE;
            iter_q  <= ITER_MAX;
            done_q  <= 1'b1;
            pass_q  <= 1'b0;
          end else begin
            slot_q <= AW'(1);
            exp_q  <= exp_step_i;
            iter_q <= iter_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign slot_o      = slot_q;
  assign exp_o       = exp_q;
  assign busy_o      = (state_q == ST_SCAN);
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign match_cnt_o = total_q;
  assign iter_cnt_o  = iter_q;

  a_r2_skip_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (slot_q != '0));
  a_r6_exp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && slot_q != AW'(1)) |-> $stable(exp_q));
  a_r3_total_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (total_q >= $past(total_q)));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r4_pass_goal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (match_cnt_o >= GOAL_C));
  a_r5_fail_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (iter_cnt_o == ITER_MAX && match_cnt_o < GOAL_C));
endmodule

// File: rtl/lfsr_selftest_chk.sv
module lfsr_selftest_chk #(
  parameter int           W        = 64,
  parameter int           DEPTH    = 16,
  parameter logic [W-1:0] SEED     = 64'hA5A5_0F0F_3C3C_5A5A,
  parameter logic [W-1:0] POLY     = 64'h231D_CEE9_1262_B8A3,
  parameter int           GOAL     = 14,
  parameter int           LOOP_MAX = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int MW = $clog2(GOAL + DEPTH),
  localparam int IW = $clog2(LOOP_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [MW-1:0] match_cnt_o,
  output logic [IW-1:0] iter_cnt_o
);
  logic [AW-1:0] slot;
  logic [W-1:0]  rd_data, exp_cur, exp_nxt;

  chk_buf_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(slot),
    .rd_data_o(rd_data)
  );

  chk_lfsr_step #(.W(W), .POLY(POLY)) u_step (
    .cur_i(exp_cur),
    .nxt_o(exp_nxt)
  );

  chk_scan_ctrl #(
    .W(W), .DEPTH(DEPTH), .SEED(SEED), .GOAL(GOAL), .LOOP_MAX(LOOP_MAX)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_data_i  (rd_data),
    .exp_step_i (exp_nxt),
    .slot_o     (slot),
    .exp_o      (exp_cur),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .match_cnt_o(match_cnt_o),
    .iter_cnt_o (iter_cnt_o)
  );
endmodule

// File: tb/lfsr_selftest_chk_bench.sv
module lfsr_selftest_chk_bench;
  localparam int           W        = 16;
  localparam int           DEPTH    = 8;
  localparam logic [W-1:0] SEED     = 16'h0001;
  localparam logic [W-1:0] POLY     = 16'h100B;
  localparam int           GOAL     = 4;
  localparam int           LOOP_MAX = 20;
  localparam int AW = $clog2(DEPTH);
  localparam int MW = $clog2(GOAL + DEPTH);
  localparam int IW = $clog2(LOOP_MAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          start = 1'b0;
  logic          busy, done, pass;
  logic [MW-1:0] match_cnt;
  logic [IW-1:0] iter_cnt;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] img [DEPTH];

  always #4 clk = ~clk;

  lfsr_selftest_chk #(
    .W(W), .DEPTH(DEPTH), .SEED(SEED), .POLY(POLY), .GOAL(GOAL), .LOOP_MAX(LOOP_MAX)
  ) u_lfsr_selftest_chk (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .busy_o(busy), .done_o(done),
    .pass_o(pass), .match_cnt_o(match_cnt), .iter_cnt_o(iter_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] state_at(input int k);
    logic [W-1:0] v = SEED;
    for (int i = 0; i < k; i++) v = v[W-1] ? ({v[W-2:0], 1'b0} ^ POLY) : {v[W-2:0], 1'b0};
    return v;
  endfunction

  task automatic model(output bit m_pass, output int m_cnt, output int m_iter);
    logic [W-1:0] v = SEED;
    m_cnt = 0; m_pass = 0; m_iter = LOOP_MAX;
    for (int it = 0; it < LOOP_MAX; it++) begin
      for (int s = 1; s < DEPTH; s++) if (img[s] == v) m_cnt++;
      if (m_cnt >= GOAL) begin
        m_pass = 1; m_iter = it + 1;
        return;
      end
      v = v[W-1] ? ({v[W-2:0], 1'b0} ^ POLY) : {v[W-2:0], 1'b0};
    end
  endtask

  task automatic load_img();
    for (int s = 0; s < DEPTH; s++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(s); wr_data = img[s];
      @(posedge clk); #1;
      wr_en = 1'b0;
    end
  endtask

  task automatic run(input string req, input bit poke_busy);
    bit e_pass; int e_cnt, e_iter, cyc;
    int held;
    model(e_pass, e_cnt, e_iter);
    load_img();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (1) begin
      @(posedge clk); #1;
      cyc++;
      if (poke_busy && cyc == 3) start = 1'b1;
      if (poke_busy && cyc == 4) start = 1'b0;
      if (done || cyc > 2000) break;
    end
    start = 1'b0;
    check(done == 1'b1, {req, " done seen"}, int'(done), 1);
    check(pass == e_pass, {req, " verdict"}, int'(pass), int'(e_pass));
    check(int'(match_cnt) == e_cnt, {req, " match total"}, int'(match_cnt), e_cnt);
    check(int'(iter_cnt) == e_iter, {req, " iterations"}, int'(iter_cnt), e_iter);
    check(cyc == e_iter * (DEPTH - 1), {req, " R7 latency"}, cyc, e_iter * (DEPTH - 1));
    held = int'(match_cnt);
    @(posedge clk); #1;
    check(done == 1'b0 && busy == 1'b0, {req, " R7 single pulse"}, int'(done), 0);
    check(int'(match_cnt) == held && pass == e_pass, {req, " R7 result held"}, int'(match_cnt), held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(busy == 0 && done == 0 && pass == 0, "R1 flags", int'({busy, done, pass}), 0);
    check(match_cnt == 0 && iter_cnt == 0, "R1 counts", int'(match_cnt) + int'(iter_cnt), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R5: empty buffer never matches
    for (int s = 0; s < DEPTH; s++) img[s] = '0;
    run("R5 all zero", 0);

    // R2: seed only in slot 0 is skipped
    img[0] = SEED;
    run("R2 slot0 seed", 0);

    // R3: duplicates counted each time, pass in iteration 1
    for (int s = 1; s <= 4; s++) img[s] = SEED;
    run("R3 R4 dup seed", 0);

    // R6: states past the top-bit carry
    for (int s = 0; s < DEPTH; s++) img[s] = '0;
    for (int s = 1; s <= 4; s++) img[s] = state_at(14 + s);
    run("R6 carry states", 0);

    // R8: start pulse during a run
    run("R8 busy start", 1);
    for (int s = 0; s < DEPTH; s++) img[s] = '0;
    run("R8 busy start fail", 1);

    // R3 R4 R5: sweep of buffer contents
    for (int p = 0; p < 36; p++) begin
      for (int s = 0; s < DEPTH; s++) begin
        int k = (p * 3 + s * s * (p % 5 + 1) + p / 4) % 26;
        img[s] = ((p + s) % 7 == 3) ? W'(p * 37 + 5) : state_at(k);
      end
      run("R3 R4 R5 sweep", (p % 6) == 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule